// File: doc/BRIEF.md
# Paired-Access Floating-Point Register File

This block is the floating-point register file of a processor core. It holds thirty-two 32-bit registers, kept apart from the integer registers. Each access moves either a single 32-bit word, used for single-precision or integer values, or a 64-bit double-precision value. A double is stored in an even/odd register pair.

It has two read ports and one write port, and each of them carries a width select. A double read or write therefore covers both halves of its pair in one cycle. Two further 32-bit paths serve moves between the two register files. The move-in path copies an integer value into one named register, and the move-out path returns one register unchanged.

A double access that names an odd base register is illegal. Such an access is never carried out, and the block raises an error flag instead. In every 64-bit value, bits [31:0] belong to the even register, which holds the lower-address word in memory. Bits [63:32] belong to the odd register, which holds the word at address+4.

Top module: `fprf_pair`

## Requirements
- R1: While `rst` is high at a rising clock edge, all 32 registers are set to zero and `acc_err` goes low on that edge.
- R2: A single read (`rd_x_en`=1, `rd_x_dbl`=0) returns register `rd_x_idx` on bits [31:0] and zero on bits [63:32]. Reads are combinational.
- R3: A double read with an even index n returns register n on bits [31:0] and register n+1 on bits [63:32].
- R4: A single write (`wr_en`=1, `wr_dbl`=0) loads `wr_data[31:0]` into register `wr_idx` on the rising edge. Bits [63:32] of `wr_data` are ignored.
- R5: A double write with an even index n loads `wr_data[31:0]` into register n and `wr_data[63:32]` into register n+1 on the same edge.
- R6: A double access with an odd index on any port is illegal. An illegal read returns zero. An illegal write changes no register. `acc_err` is high for the one cycle that follows each cycle containing an illegal access, and low otherwise.
- R7: A read in the same cycle as a write to the same register or pair returns the value from before that write.
- R8: A move-in (`mv_in_en`=1) loads `mv_in_data` unchanged into register `mv_in_idx` on the rising edge. `mv_out_data` combinationally returns register `mv_out_idx` unchanged.
- R9: When the write port and the move-in path target the same register on the same edge, the write port's value is stored.
- R10: A disabled read port (`rd_x_en`=0) returns zero and raises no error, whatever its index and width select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_en | input | 1 | Read port A enable |
| rd_a_dbl | input | 1 | Read port A width: 1 = double pair, 0 = single word |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | 64 | Read port A data |
| rd_b_en | input | 1 | Read port B enable |
| rd_b_dbl | input | 1 | Read port B width select |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_dbl | input | 1 | Write port width select |
| wr_idx | input | 5 | Write port register number |
| wr_data | input | 64 | Write port data |
| mv_in_en | input | 1 | Move-in enable |
| mv_in_idx | input | 5 | Move-in target register |
| mv_in_data | input | 32 | Move-in value from the integer side |
| mv_out_idx | input | 5 | Move-out source register |
| mv_out_data | output | 32 | Move-out value to the integer side |
| acc_err | output | 1 | Illegal-access flag, registered |

## Verification
The bench builds the block with its default parameters: 32 registers of 32 bits, which gives a 5-bit index. With these values the top pair, f30/f31, can be accessed. The bench exercises that pair for double writes and reads, and it uses index 31 as the odd base for illegal doubles. Keeping the defaults also lets every register be inspected through the move-out path after a reset that follows writes.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    // A double access must name an even base register.
    function automatic logic pair_illegal(input logic en, input logic dbl, input logic lsb);
        return en & dbl & lsb;
    endfunction

endpackage

// File: rtl/fprf_rd_port.sv
module fprf_rd_port
    import fprf_pkg::*;
#(
    parameter int NREG = 32,
    parameter int WORD = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                       en,
    input  logic                       dbl,
    input  logic [IDXW-1:0]            idx,
    input  logic [NREG-1:0][WORD-1:0]  regs,
    output logic [2*WORD-1:0]          data,
    output logic                       bad
);

    logic [IDXW-1:0] hi_idx;
    logic [WORD-1:0] lo_word;
    logic [WORD-1:0] hi_word;

    always_comb begin
        hi_idx  = {idx[IDXW-1:1], 1'b1};
        lo_word = regs[idx];
        hi_word = regs[hi_idx];
        bad     = pair_illegal(en, dbl, idx[0]);
        if (!en || bad) begin
            data = '0;
        end else if (dbl) begin
            data = {hi_word, lo_word};
        end else begin
            data = {{WORD{1'b0}}, lo_word};
        end
    end

endmodule

// File: rtl/fprf_wr_ctrl.sv
module fprf_wr_ctrl
    import fprf_pkg::*;
#(
    parameter int NREG = 32,
    parameter int WORD = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                       wr_en,
    input  logic                       wr_dbl,
    input  logic [IDXW-1:0]            wr_idx,
    input  logic [2*WORD-1:0]          wr_data,
    input  logic                       mv_en,
    input  logic [IDXW-1:0]            mv_idx,
    input  logic [WORD-1:0]            mv_data,
    input  logic [NREG-1:0][WORD-1:0]  cur,
    output logic [NREG-1:0][WORD-1:0]  nxt,
    output logic                       bad
);

    logic            wr_ok;
    logic [IDXW-1:0] pair_hi;

    assign bad     = pair_illegal(wr_en, wr_dbl, wr_idx[0]);
    assign wr_ok   = wr_en & ~bad;
    assign pair_hi = {wr_idx[IDXW-1:1], 1'b1};

    // Per register: write port first, then move-in, else hold.
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [IDXW-1:0] ME = IDXW'(i);
        assign nxt[i] = (wr_ok && wr_idx == ME)             ? wr_data[WORD-1:0]      :
                        (wr_ok && wr_dbl && pair_hi == ME)  ? wr_data[2*WORD-1:WORD] :
                        (mv_en && mv_idx == ME)             ? mv_data                :
                                                              cur[i];
    end

endmodule

// File: rtl/fprf_pair.sv
module fprf_pair #(
    parameter int NREG = 32,
    parameter int WORD = 32,
    localparam int IDXW = $clog2(NREG),
    localparam int DW   = 2 * WORD
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_a_en,
    input  logic            rd_a_dbl,
    input  logic [IDXW-1:0] rd_a_idx,
    output logic [DW-1:0]   rd_a_data,
    input  logic            rd_b_en,
    input  logic            rd_b_dbl,
    input  logic [IDXW-1:0] rd_b_idx,
    output logic [DW-1:0]   rd_b_data,
    input  logic            wr_en,
    input  logic            wr_dbl,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            mv_in_en,
    input  logic [IDXW-1:0] mv_in_idx,
    input  logic [WORD-1:0] mv_in_data,
    input  logic [IDXW-1:0] mv_out_idx,
    output logic [WORD-1:0] mv_out_data,
    output logic            acc_err
);

    typedef struct packed {
        logic [NREG-1:0][WORD-1:0] regs;
        logic                      err;
    } state_t;

    state_t                    st_d, st_q;
    logic [NREG-1:0][WORD-1:0] regs_nxt;
    logic                      bad_a, bad_b, bad_w;

    fprf_rd_port #(.NREG(NREG), .WORD(WORD)) u_rd_a (
        .en(rd_a_en), .dbl(rd_a_dbl), .idx(rd_a_idx),
        .regs(st_q.regs), .data(rd_a_data), .bad(bad_a)
    );

    fprf_rd_port #(.NREG(NREG), .WORD(WORD)) u_rd_b (
        .en(rd_b_en), .dbl(rd_b_dbl), .idx(rd_b_idx),
        .regs(st_q.regs), .data(rd_b_data), .bad(bad_b)
    );

    fprf_wr_ctrl #(.NREG(NREG), .WORD(WORD)) u_wr (
        .wr_en(wr_en), .wr_dbl(wr_dbl), .wr_idx(wr_idx), .wr_data(wr_data),
        .mv_en(mv_in_en), .mv_idx(mv_in_idx), .mv_data(mv_in_data),
        .cur(st_q.regs), .nxt(regs_nxt), .bad(bad_w)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.regs = '0;
            st_d.err  = 1'b0;
        end else begin
            st_d.regs = regs_nxt;
            st_d.err  = bad_a | bad_b | bad_w;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mv_out_data = st_q.regs[mv_out_idx];
    assign acc_err     = st_q.err;

    // R5
    dbl_write_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dbl && !wr_idx[0]) |=>
        (st_q.regs[$past(wr_idx)] == $past(wr_data[WORD-1:0]) &&
         st_q.regs[$past(wr_idx) | IDXW'(1)] == $past(wr_data[DW-1:WORD])));

    // R6
    odd_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dbl && wr_idx[0] && !mv_in_en) |=> (st_q.regs == $past(st_q.regs)));

    // R6
    odd_read_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_en && rd_a_dbl && rd_a_idx[0]) |=> acc_err);

    // R8
    move_in_chk: assert property (@(posedge clk) disable iff (rst)
        (mv_in_en && !wr_en) |=> (st_q.regs[$past(mv_in_idx)] == $past(mv_in_data)));

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_dbl && mv_in_en && wr_idx == mv_in_idx) |=>
        (st_q.regs[$past(wr_idx)] == $past(wr_data[WORD-1:0])));

    // R2
    single_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_b_en && !rd_b_dbl) |-> (rd_b_data[DW-1:WORD] == '0));

endmodule

// File: tb/fprf_pair_tb.sv
module fprf_pair_tb;

    typedef struct packed {
        logic        wen;
        logic        wdbl;
        logic [4:0]  widx;
        logic [63:0] wdat;
        logic        men;
        logic [4:0]  midx;
        logic [31:0] mdat;
        logic        rdbl;
        logic [4:0]  ridx;
        logic [4:0]  fidx;
    } row_t;

    localparam int NROW = 10;
    localparam row_t TBL [NROW] = '{
        // R4 single write f3, upper half ignored; R7 read f3 sees old value
        '{1'b1, 1'b0, 5'd3,  64'hDEAD_0000_1111_1111, 1'b0, 5'd0,  32'h0,          1'b0, 5'd3,  5'd3},
        // R5 double write f4/f5; R3 double read f2
        '{1'b1, 1'b1, 5'd4,  64'hBBBB_0005_AAAA_0004, 1'b0, 5'd0,  32'h0,          1'b1, 5'd2,  5'd5},
        // R7 single write f5 while double-reading f4
        '{1'b1, 1'b0, 5'd5,  64'h0000_0000_CCCC_0005, 1'b0, 5'd0,  32'h0,          1'b1, 5'd4,  5'd4},
        // R8 move-in f7; R2 single read f5
        '{1'b0, 1'b0, 5'd0,  64'h0,                   1'b1, 5'd7,  32'h7777_0007,  1'b0, 5'd5,  5'd7},
        // R6 odd double write f9 dropped
        '{1'b1, 1'b1, 5'd9,  64'h9999_9999_9999_9999, 1'b0, 5'd0,  32'h0,          1'b1, 5'd4,  5'd9},
        // R6 odd double read f3
        '{1'b0, 1'b0, 5'd0,  64'h0,                   1'b0, 5'd0,  32'h0,          1'b1, 5'd3,  5'd7},
        // R9 double write f30/f31 with move-in f30 same edge
        '{1'b1, 1'b1, 5'd30, 64'hFFFF_0031_EEEE_0030, 1'b1, 5'd30, 32'h1234_5678,  1'b1, 5'd30, 5'd30},
        // R3 double read of top pair
        '{1'b0, 1'b0, 5'd0,  64'h0,                   1'b0, 5'd0,  32'h0,          1'b1, 5'd30, 5'd31},
        // R4 single write f31, R8 move-in f0
        '{1'b1, 1'b0, 5'd31, 64'h0000_0000_0000_0005, 1'b1, 5'd0,  32'h0000_0009,  1'b0, 5'd31, 5'd0},
        // R3 top pair after single write to odd half
        '{1'b0, 1'b0, 5'd0,  64'h0,                   1'b0, 5'd0,  32'h0,          1'b1, 5'd30, 5'd31}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_a_en = 1'b0, rd_a_dbl = 1'b0;
    logic [4:0]  rd_a_idx = '0;
    logic [63:0] rd_a_data;
    logic        rd_b_en = 1'b0, rd_b_dbl = 1'b0;
    logic [4:0]  rd_b_idx = '0;
    logic [63:0] rd_b_data;
    logic        wr_en = 1'b0, wr_dbl = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        mv_in_en = 1'b0;
    logic [4:0]  mv_in_idx = '0;
    logic [31:0] mv_in_data = '0;
    logic [4:0]  mv_out_idx = '0;
    logic [31:0] mv_out_data;
    logic        acc_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m [32];
    logic exp_err;

    always #10 clk = ~clk;

    fprf_pair u_dut (
        .clk(clk), .rst(rst),
        .rd_a_en(rd_a_en), .rd_a_dbl(rd_a_dbl), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_en(rd_b_en), .rd_b_dbl(rd_b_dbl), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_dbl(wr_dbl), .wr_idx(wr_idx), .wr_data(wr_data),
        .mv_in_en(mv_in_en), .mv_in_idx(mv_in_idx), .mv_in_data(mv_in_data),
        .mv_out_idx(mv_out_idx), .mv_out_data(mv_out_data), .acc_err(acc_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_rd(input logic en, input logic dbl, input logic [4:0] idx);
        if (!en || (dbl && idx[0])) return 64'h0;
        if (dbl) return {m[idx | 5'd1], m[idx]};
        return {32'h0, m[idx]};
    endfunction

    function automatic string rd_tag(input logic en, input logic dbl, input logic [4:0] idx);
        if (!en) return "R10 disabled read";
        if (dbl && idx[0]) return "R6 illegal read";
        if (dbl) return "R3/R7 double read";
        return "R2/R7 single read";
    endfunction

    // Drives one cycle, checks combinational reads before the edge, error after it.
    task automatic step();
        logic illegal;
        #1;
        chk(rd_tag(rd_a_en, rd_a_dbl, rd_a_idx), rd_a_data, model_rd(rd_a_en, rd_a_dbl, rd_a_idx));
        chk(rd_tag(rd_b_en, rd_b_dbl, rd_b_idx), rd_b_data, model_rd(rd_b_en, rd_b_dbl, rd_b_idx));
        chk("R8 move-out", {32'h0, mv_out_data}, {32'h0, m[mv_out_idx]});
        illegal = (rd_a_en && rd_a_dbl && rd_a_idx[0]) || (rd_b_en && rd_b_dbl && rd_b_idx[0])
                  || (wr_en && wr_dbl && wr_idx[0]);
        @(posedge clk);
        #1;
        if (mv_in_en) m[mv_in_idx] = mv_in_data;
        if (wr_en && !(wr_dbl && wr_idx[0])) begin
            m[wr_idx] = wr_data[31:0];
            if (wr_dbl) m[wr_idx | 5'd1] = wr_data[63:32];
        end
        exp_err = illegal;
        chk("R6 error flag", {63'h0, acc_err}, {63'h0, exp_err});
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        rd_a_en = 1'b0; rd_a_dbl = 1'b0; rd_a_idx = '0;
        rd_b_en = 1'b0; rd_b_dbl = 1'b0; rd_b_idx = '0;
        wr_en = 1'b0; wr_dbl = 1'b0; wr_idx = '0; wr_data = '0;
        mv_in_en = 1'b0; mv_in_idx = '0; mv_in_data = '0;
    endtask

    task automatic check_all_zero();
        for (int i = 0; i < 32; i++) begin
            mv_out_idx = 5'(i);
            #1;
            chk("R1 register cleared", {32'h0, mv_out_data}, 64'h0);
            m[i] = 32'h0;
        end
        chk("R1 error cleared", {63'h0, acc_err}, 64'h0);
    endtask

    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all_zero();

        // Table walk: read port A from the row, port B single on fidx, move-out on fidx.
        for (int r = 0; r < NROW; r++) begin
            wr_en = TBL[r].wen; wr_dbl = TBL[r].wdbl; wr_idx = TBL[r].widx; wr_data = TBL[r].wdat;
            mv_in_en = TBL[r].men; mv_in_idx = TBL[r].midx; mv_in_data = TBL[r].mdat;
            rd_a_en = 1'b1; rd_a_dbl = TBL[r].rdbl; rd_a_idx = TBL[r].ridx;
            rd_b_en = 1'b1; rd_b_dbl = 1'b0; rd_b_idx = TBL[r].fidx;
            mv_out_idx = TBL[r].fidx;
            step();
        end
        idle_inputs();

        // R9 single write and move-in on one register
        wr_en = 1'b1; wr_idx = 5'd12; wr_data = 64'h0000_0000_AB12_CD34;
        mv_in_en = 1'b1; mv_in_idx = 5'd12; mv_in_data = 32'h5555_5555;
        step();
        idle_inputs();
        mv_out_idx = 5'd12; #1;
        chk("R9 write port wins", {32'h0, mv_out_data}, 64'h0000_0000_AB12_CD34);

        // R10 disabled port with odd double index: zero, no error
        rd_a_en = 1'b0; rd_a_dbl = 1'b1; rd_a_idx = 5'd31;
        step();

        // R6 illegal double on port B, then a legal cycle drops the flag
        rd_b_en = 1'b1; rd_b_dbl = 1'b1; rd_b_idx = 5'd31;
        step();
        idle_inputs();
        rd_a_en = 1'b1; rd_a_dbl = 1'b1; rd_a_idx = 5'd4;
        step();

        // R7 double write and double read of the same pair in one cycle
        wr_en = 1'b1; wr_dbl = 1'b1; wr_idx = 5'd4; wr_data = 64'h1357_9BDF_2468_ACE0;
        rd_a_en = 1'b1; rd_a_dbl = 1'b1; rd_a_idx = 5'd4;
        step();
        idle_inputs();
        rd_a_en = 1'b1; rd_a_dbl = 1'b1; rd_a_idx = 5'd4;
        step();

        // R1 reset after writes clears everything
        idle_inputs();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all_zero();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule